// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Realigner

This block sits between a 32-bit instruction fetch port and an instruction decoder on a core that mixes 16-bit compressed and 32-bit instructions. Memory always delivers whole words from word-aligned addresses. The block holds the address of the current instruction and cuts out the next complete instruction from those words. That instruction can start in the lower or upper half of a word. A 32-bit instruction that starts in an upper half spans two fetch words.

Toward the fetch side the block asserts a request and presents the word address it wants. A word is taken in any cycle where the request and the word's valid flag are both high. Toward the decoder the block presents the instruction, a compressed flag, its address and the address of the next sequential instruction, under a valid/ready handshake. A fetched word is kept, so its second half can be used without fetching it again. A redirect loads a new instruction address and discards any partial or pending instruction.

Top module: `cfr_realign`

## Requirements
- R1: While reset is applied, and until the first transfer after it, insn_valid is 0, fetch_req is 1, fetch_addr equals the word-aligned reset address (0 by default) and insn_data holds the no-op encoding 0x00000013.
- R2: An instruction is compressed exactly when its bits 1:0 are not 2'b11. insn_cmp reports this for the presented instruction.
- R3: When bit 1 of the instruction address is 0, the instruction comes from the whole fetch word. A compressed one is presented with bits 31:16 cleared to zero.
- R4: Fetch words are requested at consecutive word addresses during sequential flow, and each word is fetched only once. After an aligned compressed instruction is consumed, fetch_req stays low because the following halfword comes from the held word. After an aligned 32-bit instruction is consumed, fetch_req is high.
- R5: When bit 1 of the instruction address is 1, the upper half of the word becomes bits 15:0 of the instruction. If that half is compressed, the instruction is complete, and fetch_req is high once it is consumed.
- R6: A 32-bit instruction starting at a halfword offset is assembled over two words. fetch_addr advances to the following word, and that word's lower half forms bits 31:16. After the instruction is consumed, fetch_req stays low because the next instruction begins in the upper half of the held word.
- R7: insn_next_pc is insn_pc plus 2 for a compressed instruction and plus 4 otherwise. After a transfer, the next presented insn_pc equals that value.
- R8: While insn_valid is high and insn_ready is low, the presented instruction and address stay unchanged. fetch_req is never high while insn_valid is high.
- R9: A redirect clears insn_valid and any partial assembly in the next cycle. The block then requests the word at the word-aligned redirect address and uses bit 1 of the new address to pick the half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Load a new instruction address |
| redir_pc | input | ADDR_W | New instruction address |
| fetch_req | output | 1 | A fetch word is wanted |
| fetch_addr | output | ADDR_W | Word-aligned address of the wanted word |
| fetch_valid | input | 1 | fetch_word is valid this cycle |
| fetch_word | input | WORD_W | Fetched instruction word |
| insn_valid | output | 1 | A complete instruction is presented |
| insn_ready | input | 1 | Decoder takes the instruction |
| insn_data | output | WORD_W | Instruction, upper half zero if compressed |
| insn_cmp | output | 1 | Presented instruction is compressed |
| insn_pc | output | ADDR_W | Address of the presented instruction |
| insn_next_pc | output | ADDR_W | Next sequential instruction address |

## Verification
The hardest situation to reach is a redirect that lands while a spanning instruction is half assembled, or a redirect straight to a halfword offset. The fetch word then must be interpreted from a fresh address while stale lower-half data is still held. The random phase fires redirects to arbitrary halfword addresses in memory that is about half compressed encodings. It also withholds fetch words and decoder readiness at random, so redirects fall into the mid-assembly window and the reuse window many times. A directed prologue first walks a fixed aligned-compressed, spanning, unaligned-compressed, aligned-32-bit sequence.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
   localparam int ILEN = 32;
   localparam int HLEN = ILEN / 2;

   // One decision of the extractor: what to hold and what to ask for next
   typedef struct packed {
      logic [ILEN-1:0] insn;
      logic            done;
      logic            mid;
      logic            need;
   } step_t;

   function automatic logic is_cmp(input logic [1:0] low_bits);
      return low_bits != 2'b11;
   endfunction
endpackage

// File: rtl/cfr_extract.sv
module cfr_extract
   import cfr_pkg::*;
#(
   parameter int  WORD_W     = ILEN,
   parameter bit  REUSE_WORD = 1'b1
) (
   input  logic [WORD_W-1:0]   word,
   input  logic                half_sel,
   input  logic                mid,
   input  logic [WORD_W/2-1:0] held_lo,
   output step_t               step
);
   localparam int HW = WORD_W / 2;

   logic keep_need;
   logic lo_cmp;
   logic hi_cmp;

   generate
      if (WORD_W != ILEN) begin : g_bad_width
         $error("cfr_extract: WORD_W must equal ILEN");
      end
      if (REUSE_WORD) begin : g_reuse
         assign keep_need = 1'b0;
      end else begin : g_refetch
         assign keep_need = 1'b1;
      end
   endgenerate

   assign lo_cmp = is_cmp(word[1:0]);
   assign hi_cmp = is_cmp(word[HW+1:HW]);

   always_comb begin
      step = '0;
      if (mid) begin
         step.insn = {word[HW-1:0], held_lo};
         step.done = 1'b1;
         step.mid  = 1'b0;
         step.need = keep_need;
      end else if (!half_sel) begin
         step.insn = lo_cmp ? {{HW{1'b0}}, word[HW-1:0]} : word;
         step.done = 1'b1;
         step.mid  = 1'b0;
         step.need = lo_cmp ? keep_need : 1'b1;
      end else begin
         step.insn = {{HW{1'b0}}, word[WORD_W-1:HW]};
         step.done = hi_cmp;
         step.mid  = !hi_cmp;
         step.need = 1'b1;
      end
   end
endmodule

// File: rtl/cfr_pc_step.sv
module cfr_pc_step #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              cmp,
   output logic [ADDR_W-1:0] next_pc
);
   localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("cfr_pc_step: ADDR_W must be at least 3");
      end
   endgenerate

   assign next_pc = pc + (cmp ? STEP_HALF : STEP_WORD);
endmodule

// File: rtl/cfr_realign.sv
module cfr_realign
   import cfr_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              WORD_W     = ILEN,
   parameter bit              REUSE_WORD = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter logic [WORD_W-1:0] NOP_INSN = 32'h0000_0013
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_valid,
   input  logic [ADDR_W-1:0] redir_pc,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_valid,
   input  logic [WORD_W-1:0] fetch_word,
   output logic              insn_valid,
   input  logic              insn_ready,
   output logic [WORD_W-1:0] insn_data,
   output logic              insn_cmp,
   output logic [ADDR_W-1:0] insn_pc,
   output logic [ADDR_W-1:0] insn_next_pc
);
   localparam int HW = WORD_W / 2;
   localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

   generate
      if (WORD_W != 2 * HLEN) begin : g_bad_word
         $error("cfr_realign: WORD_W must be twice HLEN");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic              mid_q;
   logic              rdy_q;
   logic              need_q;
   logic [WORD_W-1:0] insn_q;
   logic [WORD_W-1:0] word_q;

   logic              take;
   logic              reuse;
   logic              consume;
   logic [WORD_W-1:0] src_word;
   step_t             step;
   logic [ADDR_W-1:0] base_addr;

   assign fetch_req = need_q & ~rdy_q;
   assign take      = fetch_valid & fetch_req & ~redir_valid;
   assign reuse     = ~need_q & ~rdy_q & ~redir_valid;
   assign consume   = rdy_q & insn_ready & ~redir_valid;
   assign src_word  = take ? fetch_word : word_q;

   assign base_addr  = {pc_q[ADDR_W-1:2], 2'b00};
   assign fetch_addr = base_addr + (mid_q ? WORD_BYTES : '0);

   cfr_extract #(
      .WORD_W     (WORD_W),
      .REUSE_WORD (REUSE_WORD)
   ) u_extract (
      .word     (src_word),
      .half_sel (pc_q[1]),
      .mid      (mid_q),
      .held_lo  (insn_q[HW-1:0]),
      .step     (step)
   );

   cfr_pc_step #(
      .ADDR_W (ADDR_W)
   ) u_pc_step (
      .pc      (pc_q),
      .cmp     (insn_cmp),
      .next_pc (insn_next_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         mid_q  <= 1'b0;
         rdy_q  <= 1'b0;
         need_q <= 1'b1;
         insn_q <= NOP_INSN;
         word_q <= '0;
      end else if (redir_valid) begin
         pc_q   <= redir_pc;
         mid_q  <= 1'b0;
         rdy_q  <= 1'b0;
         need_q <= 1'b1;
      end else if (consume) begin
         rdy_q <= 1'b0;
         pc_q  <= insn_next_pc;
      end else if (take || reuse) begin
         if (take) word_q <= fetch_word;
         insn_q <= step.insn;
         rdy_q  <= step.done;
         mid_q  <= step.mid;
         need_q <= step.need;
      end
   end

   assign insn_valid = rdy_q;
   assign insn_data  = insn_q;
   assign insn_cmp   = is_cmp(insn_q[1:0]);
   assign insn_pc    = pc_q;

   // ---------------- assertions ----------------
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q && !insn_ready && !redir_valid) |=> (rdy_q && $stable(insn_q) && $stable(pc_q)));

   assert_no_fetch_while_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> !(fetch_valid && fetch_req));

   assert_next_pc_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> (insn_pc == $past(insn_next_pc)));

   assert_redirect_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (!rdy_q && !mid_q && pc_q == $past(redir_pc)));

   assert_mid_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mid_q) |-> (insn_q[WORD_W-1:HW] == '0));

   assert_span_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_q && take) |=> (rdy_q && !mid_q));

   assert_cmp_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_cmp) |-> (insn_data[WORD_W-1:HW] == '0));
endmodule

// File: tb/test_cfr_realign.sv
module test_cfr_realign;
   localparam int AW = 32;
   localparam int MEMH = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          redir_valid = 1'b0;
   logic [AW-1:0] redir_pc = '0;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic          fetch_valid = 1'b0;
   logic [31:0]   fetch_word = '0;
   logic          insn_valid;
   logic          insn_ready = 1'b0;
   logic [31:0]   insn_data;
   logic          insn_cmp;
   logic [AW-1:0] insn_pc;
   logic [AW-1:0] insn_next_pc;

   always #2 clk = ~clk;

   cfr_realign i_cfr_realign (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .fetch_word(fetch_word), .insn_valid(insn_valid), .insn_ready(insn_ready),
      .insn_data(insn_data), .insn_cmp(insn_cmp), .insn_pc(insn_pc),
      .insn_next_pc(insn_next_pc)
   );

   logic [15:0] mem [MEMH];
   int checks = 0;
   int failures = 0;
   bit finished = 0;

   function automatic int hidx(input logic [AW-1:0] a);
      return int'((a >> 1) % MEMH);
   endfunction

   function automatic logic [31:0] word_at(input logic [AW-1:0] a);
      return {mem[(hidx(a) + 1) % MEMH], mem[hidx(a)]};
   endfunction

   function automatic logic [31:0] insn_at(input logic [AW-1:0] a);
      logic [15:0] lo = mem[hidx(a)];
      if (lo[1:0] != 2'b11) return {16'h0, lo};
      return {mem[(hidx(a) + 1) % MEMH], lo};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
   end

   // model state
   logic [AW-1:0] m_pc = '0;
   logic [AW-1:0] exp_fetch = '0;
   bit req_chk = 0;
   bit exp_req = 0;
   string req_tag = "";
   bit redir_chk = 0;
   logic [AW-1:0] redir_tgt = '0;
   bit hold_chk = 0;
   logic [31:0] hold_insn = '0;
   logic [AW-1:0] hold_pc = '0;
   int idle = 0;

   task automatic cycle(input bit directed);
      bit do_redir;
      bit consumed;
      logic [31:0] exp_i;
      bit exp_c;
      @(negedge clk);
      // deferred checks for state reached at the last edge
      if (req_chk) chk(fetch_req == exp_req, req_tag, 32'(fetch_req), 32'(exp_req));
      if (redir_chk) begin
         chk(!insn_valid && fetch_req, "R9 flush", {insn_valid, fetch_req}, 32'b01);
         chk(fetch_addr == {redir_tgt[AW-1:2], 2'b00}, "R9 fetch addr", fetch_addr, {redir_tgt[AW-1:2], 2'b00});
      end
      if (hold_chk)
         chk(insn_valid && insn_data == hold_insn && insn_pc == hold_pc, "R8 hold", insn_data, hold_insn);
      chk(!(insn_valid && fetch_req), "R8 no req while valid", {insn_valid, fetch_req}, 32'b0);
      req_chk = 0; redir_chk = 0; hold_chk = 0;

      do_redir = !directed && ($urandom % 48 == 0);
      redir_valid = do_redir;
      fetch_valid = 1'b0;
      insn_ready  = directed ? 1'b1 : ($urandom % 2 == 0);
      if (do_redir) begin
         redir_tgt = AW'(($urandom % 512) & ~1);
         redir_pc  = redir_tgt;
         m_pc      = redir_tgt;
         exp_fetch = {redir_tgt[AW-1:2], 2'b00};
         redir_chk = 1;
      end else begin
         if (fetch_req && (directed || $urandom % 10 < 7)) begin
            fetch_valid = 1'b1;
            fetch_word  = word_at(fetch_addr);
            chk(fetch_addr == exp_fetch, "R4 sequential fetch", fetch_addr, exp_fetch);
            exp_fetch = exp_fetch + 4;
         end
      end
      consumed = insn_valid && insn_ready && !do_redir;
      if (consumed) begin
         exp_i = insn_at(m_pc);
         exp_c = exp_i[1:0] != 2'b11;
         chk(insn_pc == m_pc, "R7 insn_pc", insn_pc, m_pc);
         if (!m_pc[1])
            chk(insn_data == exp_i, exp_c ? "R3 aligned compressed" : "R3 aligned word", insn_data, exp_i);
         else
            chk(insn_data == exp_i, exp_c ? "R5 halfword compressed" : "R6 spanning", insn_data, exp_i);
         chk(insn_cmp == exp_c, "R2 compressed flag", 32'(insn_cmp), 32'(exp_c));
         chk(insn_next_pc == m_pc + (exp_c ? 2 : 4), "R7 next pc", insn_next_pc, m_pc + (exp_c ? 2 : 4));
         req_chk = 1;
         exp_req = (exp_c == m_pc[1]);
         req_tag = !m_pc[1] ? "R4 request after aligned" : (exp_c ? "R5 request after halfword" : "R6 reuse after span");
         m_pc = m_pc + (exp_c ? 2 : 4);
         idle = 0;
      end else begin
         idle++;
      end
      if (insn_valid && !insn_ready && !do_redir) begin
         hold_chk = 1; hold_insn = insn_data; hold_pc = insn_pc;
      end
      if (idle > 300) begin
         failures++;
         $display("FAIL progress actual=%0d expected=%0d", idle, 300);
         summary();
      end
   endtask

   initial begin
      int junk;
      junk = $urandom(32'd20240611);
      for (int i = 0; i < MEMH; i++) begin
         mem[i] = 16'($urandom);
         if ($urandom % 2 == 0) mem[i][1:0] = 2'b11;
      end
      // directed prologue: aligned cmp, span, halfword cmp, aligned word, aligned cmp, halfword cmp
      mem[0] = 16'h4501; mem[1] = 16'h0513; mem[2] = 16'hABCD; mem[3] = 16'h8082;
      mem[4] = 16'h0093; mem[5] = 16'h0010; mem[6] = 16'h1234; mem[7] = 16'h5678;

      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(!insn_valid, "R1 reset valid", 32'(insn_valid), 32'd0);
      chk(fetch_req, "R1 reset request", 32'(fetch_req), 32'd1);
      chk(fetch_addr == '0, "R1 reset address", fetch_addr, 32'd0);
      chk(insn_data == 32'h13, "R1 reset nop", insn_data, 32'h13);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!insn_valid && fetch_req && insn_data == 32'h13, "R1 after reset", insn_data, 32'h13);

      for (int c = 0; c < 40; c++) cycle(1'b1);
      for (int c = 0; c < 6000; c++) cycle(1'b0);
      redir_valid = 1'b0;
      fetch_valid = 1'b0;
      summary();
   end
endmodule